// File: doc/BRIEF.md
# Dual-Channel Register Write Broadcaster

This block is the processor-bus front end of a two-channel serial controller. It decodes a small register address, a channel-select input and separate read and write strobes. It steers each access to one of two per-channel register banks. Each bank stands in for the channel's datapath: a set of plain registers, plus a divisor bank of three registers. A channel maps addresses 0 to 2 onto its divisor bank while bit 7 of its own line-control register (address 3) is set.

One shared alternate-function register sits at address 7 and is reachable with either channel selected. Its bit 0 turns on broadcast. While broadcast is on, every channel-register write is applied to both banks at once, which shortens start-up code when both channels get the same setup. Reads still come only from the channel named by the select input. Bits 2:1 hold a two-bit multifunction-pin code, which the block only stores and exports. A warning output flags the case where broadcast is on but the two channels' divisor-access bits disagree. In that case a broadcast write to addresses 0 to 2 would land in different registers in each channel.

Top module: `duart_bus_front`

## Requirements
- R1: After reset the shared register reads 0, so broadcast is off and the multifunction code is 0. Every channel register reads 0, and no write or read enable is active.
- R2: With broadcast off, a write changes only the bank selected by `chsel` (0 = channel A, 1 = channel B), and the other bank keeps its contents.
- R3: With broadcast on, a write to any address other than 7 stores the same byte at the same address in both banks, whatever `chsel` is.
- R4: `rdata` always shows the bank selected by `chsel`, and `ch_rd_en` (bit 0 = A, bit 1 = B) is the one-hot code of `chsel` during a read, whether broadcast is on or off.
- R5: Address 7 is one shared register, written and read through either `chsel` value. It reads back as its bits 2:0 with zeros above them, and `bcast_on` equals bit 0 and `mf_sel` equals bits 2:1.
- R6: An access to address 7 never raises `ch_wr_en` or `ch_rd_en`.
- R7: Each channel decodes addresses 0 to 2 against its own divisor-access bit (bit 7 of its address-3 register): when that bit is 1 the access goes to the divisor bank, otherwise to the plain register. This holds for reads and for broadcast writes.
- R8: `dlab_mismatch` is 1 exactly when broadcast is on and the two channels' divisor-access bits differ.
- R9: `ch_wr_en` is 0 without a write strobe. For a channel-register write it is the one-hot code of `chsel` with broadcast off and 2'b11 with broadcast on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| chsel | input | 1 | Channel select, 0 = A, 1 = B |
| wr | input | 1 | Write strobe, sampled on the clock edge |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected channel or of the shared register |
| ch_wr_en | output | 2 | Per-channel write enable |
| ch_rd_en | output | 2 | Per-channel read enable |
| bcast_on | output | 1 | Broadcast bit of the shared register |
| mf_sel | output | 2 | Multifunction-pin select code |
| dlab_mismatch | output | 1 | Broadcast on with differing divisor-access bits |

## Verification
The enables `ch_wr_en` and `ch_rd_en` and the read data are combinational from the inputs and the stored state. The bench therefore checks them one nanosecond after it drives a strobe, in the same cycle. A write commits at the next rising edge. Its effect on `rdata`, `bcast_on`, `mf_sel` and `dlab_mismatch` is checked no earlier than the following falling edge. The sweep covers every combination of the two divisor-access bits and the broadcast bit, and writes every non-control address through both select values. It then reads back all of both banks against a model kept in the bench.

// File: rtl/duart_bus_front.sv
module duart_bus_front #(
  parameter int DW       = 8,
  parameter int AW       = 3,
  parameter int AFR_ADDR = 7,
  parameter int LCR_ADDR = 3,
  parameter int DLAB_BIT = 7,
  parameter int DL_SPAN  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          chsel,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [1:0]    ch_wr_en,
  output logic [1:0]    ch_rd_en,
  output logic          bcast_on,
  output logic [1:0]    mf_sel,
  output logic          dlab_mismatch
);
  localparam int NREG = 1 << AW;
  localparam int DLW  = (DL_SPAN > 1) ? $clog2(DL_SPAN) : 1;

  logic [DW-1:0] bank [2][NREG];
  logic [DW-1:0] dl   [2][DL_SPAN];
  logic [2:0]    afr;
  logic [1:0]    dlab;

  wire       afr_hit = (addr == AW'(AFR_ADDR));
  wire       dl_zone = (addr < AW'(DL_SPAN));
  wire [1:0] sel_oh  = chsel ? 2'b10 : 2'b01;

  for (genvar g = 0; g < 2; g++) begin : g_dlab
    assign dlab[g] = bank[g][LCR_ADDR][DLAB_BIT];
  end

  assign ch_wr_en      = (wr && !afr_hit) ? (afr[0] ? 2'b11 : sel_oh) : 2'b00;
  assign ch_rd_en      = (rd && !afr_hit) ? sel_oh : 2'b00;
  assign bcast_on      = afr[0];
  assign mf_sel        = afr[2:1];
  assign dlab_mismatch = afr[0] & (dlab[0] ^ dlab[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      afr <= '0;
      for (int c = 0; c < 2; c++) begin
        for (int i = 0; i < NREG; i++) bank[c][i] <= '0;
        for (int i = 0; i < DL_SPAN; i++) dl[c][i] <= '0;
      end
    end else begin
      if (wr && afr_hit) afr <= wdata[2:0];
      for (int c = 0; c < 2; c++) begin
        if (ch_wr_en[c]) begin
          if (dlab[c] && dl_zone) dl[c][addr[DLW-1:0]] <= wdata;
          else                    bank[c][addr]        <= wdata;
        end
      end
    end
  end

  always_comb begin
    if (afr_hit)                   rdata = {{(DW-3){1'b0}}, afr};
    else if (dlab[chsel] && dl_zone) rdata = dl[chsel][addr[DLW-1:0]];
    else                           rdata = bank[chsel][addr];
  end
endmodule

// File: rtl/duart_bus_front_chk.sv
module duart_bus_front_chk #(
  parameter int AW       = 3,
  parameter int DW       = 8,
  parameter int AFR_ADDR = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          chsel,
  input logic          wr,
  input logic [DW-1:0] wdata,
  input logic [1:0]    ch_wr_en,
  input logic [1:0]    ch_rd_en,
  input logic          bcast_on,
  input logic [1:0]    mf_sel,
  input logic          dlab_mismatch
);
  wire afr_wr = wr && (addr == AW'(AFR_ADDR));

  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_rd_en)); // R4
  AST_RD_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (!rst_n) (ch_rd_en != 2'b00) |-> ch_rd_en[chsel]); // R4
  AST_AFR_NO_CH_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) (addr == AW'(AFR_ADDR)) |-> (ch_wr_en == 2'b00 && ch_rd_en == 2'b00)); // R6
  AST_AFR_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n) afr_wr |=> (bcast_on == $past(wdata[0]) && mf_sel == $past(wdata[2:1]))); // R5
  AST_AFR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !afr_wr |=> ($stable(bcast_on) && $stable(mf_sel))); // R5
  AST_MISMATCH_NEEDS_BCAST: assert property (@(posedge clk) disable iff (!rst_n) dlab_mismatch |-> bcast_on); // R8
  AST_NO_STROBE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n) !wr |-> (ch_wr_en == 2'b00)); // R9
  AST_BCAST_BOTH: assert property (@(posedge clk) disable iff (!rst_n) (wr && bcast_on && !afr_wr) |-> (ch_wr_en == 2'b11)); // R3
endmodule

bind duart_bus_front duart_bus_front_chk #(.AW(AW), .DW(DW), .AFR_ADDR(AFR_ADDR)) u_chk (.*);

// File: tb/duart_bus_front_test.sv
module duart_bus_front_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       chsel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] ch_wr_en, ch_rd_en, mf_sel;
  logic       bcast_on, dlab_mismatch;

  int checks = 0, errors = 0;
  logic [7:0] m_reg [2][8];
  logic [7:0] m_dl  [2][3];
  logic [2:0] m_afr;

  duart_bus_front uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input int c, input int a);
    if (a == 7) return {5'b0, m_afr};
    if (a < 3 && m_reg[c][3][7]) return m_dl[c][a];
    return m_reg[c][a];
  endfunction

  task automatic do_write(input int c, input int a, input logic [7:0] d);
    logic [1:0] exp_en;
    @(negedge clk);
    chsel = c[0]; addr = a[2:0]; wdata = d; wr = 1'b1;
    #1;
    exp_en = (a == 7) ? 2'b00 : (m_afr[0] ? 2'b11 : (c[0] ? 2'b10 : 2'b01));
    chk(a == 7 ? "R6" : (m_afr[0] ? "R3" : "R9"), ch_wr_en, exp_en);
    if (a == 7) m_afr = d[2:0];
    else
      for (int k = 0; k < 2; k++)
        if (exp_en[k]) begin
          if (a < 3 && m_reg[k][3][7]) m_dl[k][a] = d;
          else m_reg[k][a] = d;
        end
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input int c, input int a, input string req);
    @(negedge clk);
    chsel = c[0]; addr = a[2:0]; rd = 1'b1;
    #1;
    chk(req, rdata, model_rd(c, a));
    chk(a == 7 ? "R6" : "R4", ch_rd_en, (a == 7) ? 0 : (c[0] ? 2 : 1));
    rd = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_afr = '0;
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 8; i++) m_reg[c][i] = '0;
      for (int i = 0; i < 3; i++) m_dl[c][i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1", {bcast_on, mf_sel, dlab_mismatch}, 0);
    chk("R1", {ch_wr_en, ch_rd_en}, 0);
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 8; a++) do_read(c, a, "R1");

    for (int r = 0; r < 8; r++) begin
      do_write(r & 1, 7, 8'h00);
      do_write(0, 3, {r[0], 7'h05});
      do_write(1, 3, {r[1], 7'h0a});
      do_write((r & 1) ^ 1, 7, {5'b11111, r[1:0], r[2]});
      @(negedge clk);
      chk("R5", bcast_on, r[2]);
      chk("R5", mf_sel, r[1:0]);
      chk("R8", dlab_mismatch, r[2] & (r[0] ^ r[1]));
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 7; a++)
          if (a != 3) do_write(c, a, 8'((r * 37 + c * 101 + a * 13 + 1) & 255));
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 8; a++)
          do_read(c, a, (a < 3) ? "R7" : (a == 7 ? "R5" : (r[2] ? "R3" : "R2")));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule